// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns read and write requests from an internal bus controller into external memory cycles on a shared address/data bus. Each request carries an address, a byte or word size, a direction and write data. Every external cycle has four phases: idle, address, data and end. During the address phase the block raises an address-latch strobe, so that an outside latch can capture the address from the shared lines. During the data phase it pulls a read or write strobe low. When the last cycle finishes, it returns a one-cycle done pulse.

The data bus width is chosen at run time. Two configuration bits either fix the width at 8 or 16 bits, or hand the choice to an external width pin. On an 8-bit bus, a word access is split into two byte cycles. Each of these cycles has its own latch pulse. Read data from both cycles is merged into one 16-bit result.

A role bit decides what the high-byte control pin does. It acts either as a byte-high enable, which is address-like and stays valid through the cycle, or as a write strobe for the high byte alone.

Top module: `mux_bus_seq`

## Requirements
- R1: `ale` is high in exactly one cycle of each bus cycle, the address phase. In that cycle `ad_oe`=1 and `ad_out` holds the bus address. `ale` is low at all other times, including reset and idle.
- R2: The data phase is the cycle right after `ale`. It is the only cycle in which `rd_n` or `wr_n` may be low. `rd_n` and `wr_n` are never low together.
- R3: The width is sampled when a request is accepted. {`cfg_wa`,`cfg_wb`}=10 gives a 16-bit bus. 01 and 00 give an 8-bit bus. 11 follows `width_pin` (1 gives 16 bits, 0 gives 8 bits). `width_pin` is ignored in the other three settings, and changes to it after acceptance have no effect on the access in progress.
- R4: With `cfg_hb_role`=1 (byte-high enable) on a 16-bit bus, `hb_n` is low in the address and data phases of word accesses and odd-address byte accesses. It is high for even-address bytes. It is always high on an 8-bit bus.
- R5: On a 16-bit bus, address bit 0 selects the lane. An even byte uses `ad[7:0]` and an odd byte uses `ad[15:8]`. A word uses all 16 lines at the address with bit 0 cleared. Write bytes come from `req_wdata[7:0]`, and lines that carry no data are driven to 0.
- R6: With `cfg_hb_role`=0 (write-high strobe), `hb_n` goes low only in the data phase of a write that places data on the upper lane. It is never low on reads. In this mode `wr_n` goes low only when the lower lane is written.
- R7: With `cfg_hb_role`=1, `wr_n` is low in the data phase of every write.
- R8: On an 8-bit bus, a word access runs two byte cycles. The first is at the even address and the second at the odd address, and each has its own `ale` pulse. The low byte is sent first, and all data travels on `ad[7:0]`.
- R9: At `done` of a read, `rd_data` holds the word as {high byte, low byte}. A byte read is returned zero-extended, taken from the lane that R5 and R8 assign to it.
- R10: `done` is a single-cycle pulse in the end phase of the last cycle of an access. `req_ready` is high only in idle, and a request is taken when `req_valid` and `req_ready` are both high.
- R11: `ad_oe` is high in the address phase and in the data phase of writes. It is low during read data, end and idle, and `ad_out` is 0 whenever `ad_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | AW | Byte address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | Access complete pulse |
| rd_data | output | 16 | Assembled read data |
| cfg_hb_role | input | 1 | 1 = byte-high enable, 0 = write-high strobe |
| cfg_wa | input | 1 | Width configuration bit A |
| cfg_wb | input | 1 | Width configuration bit B |
| width_pin | input | 1 | External width select (1 = 16-bit) |
| ale | output | 1 | Address latch strobe, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe (low-byte strobe in write-high mode), active low |
| hb_n | output | 1 | High-byte control, active low |
| ad_out | output | 16 | Address/data bus output value |
| ad_oe | output | 1 | Address/data bus output enable |
| ad_in | input | 16 | Address/data bus input value |

## Verification
The bench applies all four width settings and sets the width pin to the opposite of what the fixed modes would need. It also flips the pin right after a request is accepted. A decoder that read the pin in a fixed mode, or read it live during the access, would then produce the wrong number of `ale` pulses or put the address on the wrong lanes. Odd-address and even-address bytes, and words on both bus widths, are run under each role of the high-byte pin. A design that swapped lanes, kept the enable asserted for even bytes, or pulsed the write-high strobe on reads would show a wrong `hb_n`, `wr_n` or `ad_out` in a single compared cycle. Reads of split words check byte order and merging: a design that reversed the halves or failed to clear stale upper bits would return a wrong `rd_data`.

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_word,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [15:0]   rd_data,
  input  logic          cfg_hb_role,
  input  logic          cfg_wa,
  input  logic          cfg_wb,
  input  logic          width_pin,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          hb_n,
  output logic [15:0]   ad_out,
  output logic          ad_oe,
  input  logic [15:0]   ad_in
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_END} st_t;

  st_t           st;
  logic [AW-1:0] cur_addr;
  logic          is_wr, is_word, bus16, second;
  logic [15:0]   wdat;
  logic [7:0]    rd_lo, rd_hi;

  wire wide_now = cfg_wa & (~cfg_wb | width_pin);
  wire split    = is_word & ~bus16;
  wire in_addr  = (st == S_ADDR);
  wire in_data  = (st == S_DATA);
  wire hi_lane  = bus16 & (is_word | cur_addr[0]);
  wire lo_lane  = ~bus16 | is_word | ~cur_addr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      is_wr    <= 1'b0;
      is_word  <= 1'b0;
      bus16    <= 1'b0;
      second   <= 1'b0;
      wdat     <= '0;
      rd_lo    <= '0;
      rd_hi    <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          is_wr    <= req_write;
          is_word  <= req_word;
          wdat     <= req_wdata;
          bus16    <= wide_now;
          second   <= 1'b0;
          cur_addr <= req_word ? {req_addr[AW-1:1], 1'b0} : req_addr;
          st       <= S_ADDR;
        end
        S_ADDR: st <= S_DATA;
        S_DATA: begin
          if (!is_wr) begin
            if (bus16) begin
              if (is_word) begin
                rd_hi <= ad_in[15:8];
                rd_lo <= ad_in[7:0];
              end else begin
                rd_hi <= 8'h00;
                rd_lo <= cur_addr[0] ? ad_in[15:8] : ad_in[7:0];
              end
            end else if (second) begin
              rd_hi <= ad_in[7:0];
            end else begin
              rd_hi <= 8'h00;
              rd_lo <= ad_in[7:0];
            end
          end
          st <= S_END;
        end
        default: begin
          if (split && !second) begin
            second      <= 1'b1;
            cur_addr[0] <= 1'b1;
            st          <= S_ADDR;
          end else begin
            st <= S_IDLE;
          end
        end
      endcase
    end
  end

  logic [15:0] wr_bus;
  always_comb begin
    if (!bus16)
      wr_bus = {8'h00, second ? wdat[15:8] : wdat[7:0]};
    else if (is_word)
      wr_bus = wdat;
    else if (cur_addr[0])
      wr_bus = {wdat[7:0], 8'h00};
    else
      wr_bus = {8'h00, wdat[7:0]};
  end

  assign req_ready = (st == S_IDLE);
  assign done      = (st == S_END) & ~(split & ~second);
  assign rd_data   = {rd_hi, rd_lo};
  assign ale       = in_addr;
  assign rd_n      = ~(in_data & ~is_wr);
  assign wr_n      = ~(in_data & is_wr & (cfg_hb_role | lo_lane));
  assign hb_n      = cfg_hb_role ? ~((in_addr | in_data) & hi_lane)
                                 : ~(in_data & is_wr & hi_lane);
  assign ad_oe     = in_addr | (in_data & is_wr);
  assign ad_out    = in_addr ? 16'(cur_addr) : (in_data & is_wr) ? wr_bus : 16'h0000;

endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ale,
  input logic rd_n,
  input logic wr_n,
  input logic hb_n,
  input logic ad_oe,
  input logic done,
  input logic req_ready,
  input logic cfg_hb_role
);

  p_ale_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (ad_oe && rd_n && wr_n));

  p_ale_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && (!rd_n || !wr_n || !hb_n)));

  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  p_wrh_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_hb_role && !rd_n) |-> hb_n);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  p_read_float_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);

endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
  .hb_n(hb_n), .ad_oe(ad_oe), .done(done), .req_ready(req_ready),
  .cfg_hb_role(cfg_hb_role)
);

// File: tb/mux_bus_seq_test.sv
module mux_bus_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic req_ready, done, ale, rd_n, wr_n, hb_n, ad_oe;
  logic [15:0] rd_data, ad_out;
  logic [15:0] ad_in;
  logic cfg_hb_role = 1'b1, cfg_wa = 1'b1, cfg_wb = 1'b0, width_pin = 1'b1;

  int n_tests = 0, n_fail = 0;
  logic [7:0] mem [256];
  logic [7:0] la = '0;
  logic mode16 = 1'b1;

  always #10 clk = ~clk;

  mux_bus_seq #(.AW(16)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rd_data(rd_data),
    .cfg_hb_role(cfg_hb_role), .cfg_wa(cfg_wa), .cfg_wb(cfg_wb),
    .width_pin(width_pin), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .hb_n(hb_n),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
  );

  always @(posedge clk) if (ale) la <= ad_out[7:0];

  always_comb begin
    if (mode16) ad_in = {mem[{la[7:1], 1'b1}], mem[{la[7:1], 1'b0}]};
    else        ad_in = {8'hEE, mem[la]};
  end

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic cmp_all(string req, logic e_ale, logic e_rd, logic e_wr, logic e_hb,
                         logic e_oe, logic [15:0] e_ad, logic e_done, logic e_rdy);
    chk(req, "ale", 16'(ale), 16'(e_ale));
    chk(req, "rd_n", 16'(rd_n), 16'(e_rd));
    chk(req, "wr_n", 16'(wr_n), 16'(e_wr));
    chk(req, "hb_n", 16'(hb_n), 16'(e_hb));
    chk(req, "ad_oe", 16'(ad_oe), 16'(e_oe));
    chk(req, "ad_out", ad_out, e_ad);
    chk(req, "done", 16'(done), 16'(e_done));
    chk(req, "req_ready", 16'(req_ready), 16'(e_rdy));
  endtask

  // Behavioural model: builds the expected phases of one access and compares each cycle
  task automatic run(bit wr, bit word, logic [15:0] addr, logic [15:0] wd,
                     bit wa, bit wb, bit pin, bit role);
    bit b16;
    int nsub;
    logic [15:0] base;
    case ({wa, wb})
      2'b10:   b16 = 1'b1;
      2'b11:   b16 = pin;
      default: b16 = 1'b0;
    endcase
    nsub = (word && !b16) ? 2 : 1;
    base = word ? {addr[15:1], 1'b0} : addr;
    cfg_wa = wa; cfg_wb = wb; width_pin = pin; cfg_hb_role = role; mode16 = b16;
    req_valid = 1'b1; req_write = wr; req_word = word; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    #1 req_valid = 1'b0;
    width_pin = ~pin;   // R3: late pin change must not matter
    for (int k = 0; k < nsub; k++) begin
      logic [15:0] ak, dexp;
      bit hi, lo;
      ak = (nsub == 2) ? (base | 16'(k)) : base;
      hi = b16 && (word || ak[0]);
      lo = !b16 || word || !ak[0];
      if (!b16)        dexp = {8'h00, (k == 1) ? wd[15:8] : wd[7:0]};
      else if (word)   dexp = wd;
      else if (ak[0])  dexp = {wd[7:0], 8'h00};
      else             dexp = {8'h00, wd[7:0]};
      @(negedge clk);  // address phase: R1 R3 R4 R5 R8
      cmp_all("R1/R4/R8", 1'b1, 1'b1, 1'b1, role ? !hi : 1'b1, 1'b1, ak, 1'b0, 1'b0);
      @(negedge clk);  // data phase: R2 R5 R6 R7 R11
      cmp_all("R2/R5/R6/R7/R11", 1'b0, wr ? 1'b1 : 1'b0,
              (wr && (role || lo)) ? 1'b0 : 1'b1,
              role ? !hi : !(wr && hi), wr, wr ? dexp : 16'h0000, 1'b0, 1'b0);
      @(negedge clk);  // end phase: R10
      cmp_all("R10", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, (k == nsub - 1), 1'b0);
      if (k == nsub - 1 && !wr) begin
        if (word) chk("R9", "rd_data", rd_data, {mem[base[7:0] | 8'h01], mem[base[7:0]]});
        else      chk("R9", "rd_data", rd_data, {8'h00, mem[addr[7:0]]});
      end
    end
    @(negedge clk);
    cmp_all("R10", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 3));
    repeat (2) @(negedge clk);
    cmp_all("R1/R10 reset", 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    // 16-bit fixed, pin low ignored (R3), byte-high enable role
    run(0, 1, 16'h0031, 16'h0000, 1, 0, 0, 1);   // word read, bit 0 cleared
    run(1, 1, 16'h0040, 16'hBEEF, 1, 0, 0, 1);
    run(1, 0, 16'h0043, 16'h00A5, 1, 0, 0, 1);   // odd byte write
    run(1, 0, 16'h0044, 16'h005A, 1, 0, 0, 1);   // even byte write
    run(0, 0, 16'h0017, 16'h0000, 1, 0, 0, 1);   // odd byte read
    run(0, 0, 16'h0018, 16'h0000, 1, 0, 0, 1);   // even byte read
    // 8-bit fixed, pin high ignored (R3, R8)
    run(0, 1, 16'h0025, 16'h0000, 0, 1, 1, 1);
    run(1, 1, 16'h0026, 16'h1234, 0, 1, 1, 1);
    run(0, 0, 16'h0029, 16'h0000, 0, 0, 1, 1);
    // pin-selected width
    run(0, 1, 16'h0050, 16'h0000, 1, 1, 1, 1);
    run(0, 1, 16'h0052, 16'h0000, 1, 1, 0, 1);
    run(1, 0, 16'h0061, 16'h00C3, 1, 1, 1, 1);
    // write-high strobe role (R6)
    run(1, 1, 16'h0070, 16'hCAFE, 1, 0, 0, 0);
    run(1, 0, 16'h0071, 16'h0077, 1, 0, 0, 0);
    run(1, 0, 16'h0072, 16'h0066, 1, 0, 0, 0);
    run(0, 1, 16'h0074, 16'h0000, 1, 0, 0, 0);
    run(0, 0, 16'h0075, 16'h0000, 1, 0, 0, 0);
    run(1, 1, 16'h0078, 16'h9A9B, 0, 1, 0, 0);   // split write, low lane only
    run(0, 1, 16'h007A, 16'h0000, 1, 1, 0, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule